// File: doc/BRIEF.md
# Microprogram Sequencer with Writable Control Store

This block holds the microcode of a microprogrammed processor and chooses which microinstruction runs next. Each cycle it presents the current control word to the datapath. When that cycle ends it records the word's successor field and its jump bits, along with the N and Z flags that the datapath's ALU produced while executing the word. From those recorded values, and from the byte the datapath currently holds in its fetched-byte register, it forms the address of the following word. Two kinds of branch are supported:

- A two-way branch on a flag raises the top address bit.
- A multiway dispatch merges the fetched byte into the low address bits, so an opcode can select a handler directly.

A load port lets a testbench or a boot loader fill the store word by word. The port stays usable at all times. An entry address input decides where execution begins after reset. A control word that selects the reserved B-bus source code stops the sequencer: the halt output rises, and the address stays frozen until the next reset. The datapath, the ALU and the memory system are outside this block. Only their flags and their byte register reach it.

Top module: `microseq`

## Requirements
- R1: The store holds 2^9 words of 36 bits. A word written through the load port (`wr_en_i` high at a clock edge, `wr_addr_i`, `wr_data_i`) appears on `uinstr_o` in every later cycle in which `mpc_o` equals its address.
- R2: While `rst_ni` is low, the sequencer samples `entry_i` on each clock edge. In the first cycle after `rst_ni` rises, `mpc_o` equals that entry address and `halt_o` is low, as long as the entry word is legal.
- R3: Bit 25 (test N) and bit 24 (test Z) select a two-way branch. The flags tested are the `n_i`/`z_i` values present at the clock edge that ends the branching word. The address that follows is the 9-bit successor field in bits 35:27 when the tested flag is 0. When the tested flag is 1, it is that field with bit 8 set, so the two targets differ by 0x100.
- R4: When bit 26 (byte dispatch) is set, the address that follows is the successor field ORed with the `mbr_i` value present during the following cycle. For example, field 0x100 with byte 0x15 gives 0x115.
- R5: A dispatch word with successor field 0 leads to the address equal to the byte value.
- R6: A word whose bits 3:0 equal 15 raises `halt_o` in the same cycle it is current. From then until reset, `halt_o` stays high and `mpc_o` keeps the same value, whatever the flags and byte inputs do.
- R7: While halted, the store still accepts writes: `uinstr_o` shows a word newly written at the halt address. A new reset restarts execution at `entry_i` with `halt_o` low.
- R8: A word with bits 26:24 all zero is followed by its successor field, and the bench's model of the sequence holds across random programs.
- R9: A flag whose test bit is clear has no effect on the next address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| entry_i | input | 9 | Address where execution starts after reset |
| wr_en_i | input | 1 | Store write strobe |
| wr_addr_i | input | 9 | Store write address |
| wr_data_i | input | 36 | Store write data |
| n_i | input | 1 | Negative flag from the current word's ALU operation |
| z_i | input | 1 | Zero flag from the current word's ALU operation |
| mbr_i | input | 8 | Fetched-byte register from the datapath |
| uinstr_o | output | 36 | Control word at the current address |
| mpc_o | output | 9 | Current microprogram address |
| halt_o | output | 1 | Illegal B-source code reached; sequencer stopped |

## Verification
The assertions check four things on every cycle:
- a taken flag test always lands in the upper half of the store;
- a dispatch address always contains every set bit of the byte;
- a non-dispatch address keeps the low bits of the successor field;
- once halt is raised, it and the address stay fixed.

Other behaviours can only be shown by the bench's scenarios. These are which flag value leads to which exact target, what the entry address is after reset, whether loaded words come back intact, and whether execution restarts after a halt. The bench runs directed branch, dispatch and halt sequences, then random programs under random flags and bytes, and compares every cycle with a bench model.

// File: rtl/microseq_pkg.sv
package microseq_pkg;

    // Default geometry of the sequencer
    localparam int unsigned ADDR_W_DEF = 9;
    localparam int unsigned WORD_W_DEF = 36;
    localparam int unsigned BYTE_W_DEF = 8;
    localparam int unsigned BSEL_W_DEF = 4;
    localparam int unsigned JUMP_W     = 3;

    // Jump control bits, top to bottom: byte dispatch, test N, test Z
    typedef struct packed {
        logic dispatch;
        logic test_n;
        logic test_z;
    } jump_t;

endpackage

// File: rtl/microseq_store.sv
module microseq_store #(
    parameter int unsigned ADDR_W = microseq_pkg::ADDR_W_DEF,
    parameter int unsigned WORD_W = microseq_pkg::WORD_W_DEF
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Write port: one word per clock edge
    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Read port is asynchronous so the addressed word is current this cycle
    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/microseq_fields.sv
module microseq_fields #(
    parameter int unsigned ADDR_W   = microseq_pkg::ADDR_W_DEF,
    parameter int unsigned BSEL_W   = microseq_pkg::BSEL_W_DEF,
    parameter int unsigned HALT_SEL = (1 << BSEL_W) - 1
) (
    input  logic [ADDR_W+microseq_pkg::JUMP_W-1:0] head_i,
    input  logic [BSEL_W-1:0]                      bsel_i,
    output logic [ADDR_W-1:0]                      succ_o,
    output microseq_pkg::jump_t                    jump_o,
    output logic                                   illegal_o
);
    localparam int unsigned JW = microseq_pkg::JUMP_W;

    always_comb begin
        succ_o    = head_i[ADDR_W+JW-1:JW];
        jump_o    = microseq_pkg::jump_t'(head_i[JW-1:0]);
        illegal_o = (bsel_i == BSEL_W'(HALT_SEL));
    end

endmodule

// File: rtl/microseq_next.sv
module microseq_next #(
    parameter int unsigned ADDR_W = microseq_pkg::ADDR_W_DEF,
    parameter int unsigned BYTE_W = microseq_pkg::BYTE_W_DEF
) (
    input  logic [ADDR_W-1:0]   succ_i,
    input  microseq_pkg::jump_t jump_i,
    input  logic                n_i,
    input  logic                z_i,
    input  logic [BYTE_W-1:0]   byte_i,
    output logic [ADDR_W-1:0]   addr_o
);
    localparam int unsigned PAD_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] byte_ext;
    logic [ADDR_W-1:0] flag_ext;
    logic              taken;

    // Widen the byte to the address width; structure depends on the width gap
    generate
        if (PAD_W > 0) begin : g_pad
            assign byte_ext = {{PAD_W{1'b0}}, byte_i};
        end else begin : g_nopad
            assign byte_ext = byte_i[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        taken    = (jump_i.test_n & n_i) | (jump_i.test_z & z_i);
        flag_ext = '0;
        flag_ext[ADDR_W-1] = taken;
        if (jump_i.dispatch) begin
            addr_o = succ_i | byte_ext;
        end else begin
            addr_o = succ_i | flag_ext;
        end
    end

endmodule

// File: rtl/microseq.sv
module microseq #(
    parameter int unsigned ADDR_W = microseq_pkg::ADDR_W_DEF,
    parameter int unsigned WORD_W = microseq_pkg::WORD_W_DEF,
    parameter int unsigned BYTE_W = microseq_pkg::BYTE_W_DEF,
    parameter int unsigned BSEL_W = microseq_pkg::BSEL_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] entry_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              n_i,
    input  logic              z_i,
    input  logic [BYTE_W-1:0] mbr_i,
    output logic [WORD_W-1:0] uinstr_o,
    output logic [ADDR_W-1:0] mpc_o,
    output logic              halt_o
);
    import microseq_pkg::*;

    localparam int unsigned HEAD_W = ADDR_W + JUMP_W;

    // Recorded state of the word that ran last, plus the sticky halt
    typedef struct packed {
        logic [ADDR_W-1:0] succ;
        jump_t             jump;
        logic              n;
        logic              z;
        logic              halt;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] addr_cur;
    logic [WORD_W-1:0] word_cur;
    logic [ADDR_W-1:0] succ_cur;
    jump_t             jump_cur;
    logic              illegal_cur;

    microseq_next #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) i_next (
        .succ_i (st_q.succ),
        .jump_i (st_q.jump),
        .n_i    (st_q.n),
        .z_i    (st_q.z),
        .byte_i (mbr_i),
        .addr_o (addr_cur)
    );

    microseq_store #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) i_store (
        .clk_i   (clk_i),
        .we_i    (wr_en_i),
        .waddr_i (wr_addr_i),
        .wdata_i (wr_data_i),
        .raddr_i (addr_cur),
        .rdata_o (word_cur)
    );

    microseq_fields #(
        .ADDR_W (ADDR_W),
        .BSEL_W (BSEL_W)
    ) i_fields (
        .head_i    (word_cur[WORD_W-1 -: HEAD_W]),
        .bsel_i    (word_cur[BSEL_W-1:0]),
        .succ_o    (succ_cur),
        .jump_o    (jump_cur),
        .illegal_o (illegal_cur)
    );

    assign uinstr_o = word_cur;
    assign mpc_o    = addr_cur;
    assign halt_o   = st_q.halt | illegal_cur;

    always_comb begin
        st_d = st_q;
        if (halt_o) begin
            // Park on the current address: plain successor, no jump bits
            st_d.succ = addr_cur;
            st_d.jump = '0;
            st_d.halt = 1'b1;
        end else begin
            st_d.succ = succ_cur;
            st_d.jump = jump_cur;
            st_d.n    = n_i;
            st_d.z    = z_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.succ <= entry_i;
            st_q.jump <= '0;
            st_q.n    <= 1'b0;
            st_q.z    <= 1'b0;
            st_q.halt <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // A taken flag test lands in the upper half of the store
    p_flag_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.jump.dispatch &&
         ((st_q.jump.test_n && st_q.n) || (st_q.jump.test_z && st_q.z)))
        |-> mpc_o[ADDR_W-1]);

    // Without dispatch, the low bits follow the recorded successor field
    p_low_bits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.jump.dispatch |-> (mpc_o[ADDR_W-2:0] == st_q.succ[ADDR_W-2:0]));

    // A dispatch address contains every set bit of the byte
    p_byte_merge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.jump.dispatch |-> ((mpc_o[BYTE_W-1:0] & mbr_i) == mbr_i));

    // Halt is sticky and freezes the address
    p_halt_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |=> (halt_o && $stable(mpc_o)));

endmodule

// File: tb/test_microseq.sv
`timescale 1ns/1ps
module test_microseq;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [8:0]  entry_i = '0;
    logic        wr_en_i = 1'b0;
    logic [8:0]  wr_addr_i = '0;
    logic [35:0] wr_data_i = '0;
    logic        n_i = 1'b0;
    logic        z_i = 1'b0;
    logic [7:0]  mbr_i = '0;
    logic [35:0] uinstr_o;
    logic [8:0]  mpc_o;
    logic        halt_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model
    logic [35:0] mdl [512];
    logic [8:0]  m_succ;
    logic [2:0]  m_jump;
    logic        m_n, m_z, m_halt;

    microseq i_microseq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .entry_i   (entry_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .n_i       (n_i),
        .z_i       (z_i),
        .mbr_i     (mbr_i),
        .uinstr_o  (uinstr_o),
        .mpc_o     (mpc_o),
        .halt_o    (halt_o)
    );

    always #2 clk_i = ~clk_i;

    function automatic logic [35:0] mk(input logic [8:0] succ, input logic disp,
                                       input logic tn, input logic tz, input logic [3:0] bsel);
        return {succ, disp, tn, tz, 20'hA5C3E, bsel};
    endfunction

    // Expected address from the requirements: R3, R4, R5, R9
    function automatic logic [8:0] exp_addr(input logic [7:0] b);
        if (m_jump[2]) return m_succ | {1'b0, b};
        return m_succ | {((m_jump[1] & m_n) | (m_jump[0] & m_z)), 8'h00};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic begin_reset(input logic [8:0] e);
        @(negedge clk_i);
        rst_ni  = 1'b0;
        entry_i = e;
        repeat (2) @(negedge clk_i);
    endtask

    task automatic end_reset();
        rst_ni = 1'b1;
        m_succ = entry_i; m_jump = '0; m_n = 0; m_z = 0; m_halt = 0;
    endtask

    task automatic load(input logic [8:0] a, input logic [35:0] w);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = w;
        @(negedge clk_i);
        wr_en_i = 1'b0;
        mdl[a] = w;
    endtask

    // Called at a falling edge; drives inputs, checks this cycle, crosses one rising edge
    task automatic step(input logic n, input logic z, input logic [7:0] b,
                        input int want, input string tag);
        logic [8:0] ea;
        logic       eh;
        n_i = n; z_i = z; mbr_i = b;
        #1;
        ea = exp_addr(b);
        eh = m_halt | (mdl[ea][3:0] == 4'hF);
        chk(mpc_o == ea, {tag, " address"}, 36'(mpc_o), 36'(ea));
        if (want >= 0) chk(mpc_o == 9'(want), {tag, " directed address"}, 36'(mpc_o), 36'(want));
        chk(uinstr_o == mdl[ea], {tag, " word"}, uinstr_o, mdl[ea]);
        chk(halt_o == eh, {tag, " halt"}, 36'(halt_o), 36'(eh));
        if (eh) begin
            m_succ = ea; m_jump = '0; m_halt = 1'b1;
        end else begin
            m_succ = mdl[ea][35:27]; m_jump = mdl[ea][26:24]; m_n = n; m_z = z;
        end
        @(negedge clk_i);
    endtask

    function automatic logic [35:0] rand_word();
        logic [35:0] w;
        w = {4'($urandom()), 32'($urandom())};
        if (w[3:0] == 4'hF && ($urandom() % 16) != 0) w[3:0] = 4'h0;
        return w;
    endfunction

    initial begin
        void'($urandom(32'd2718));
        // Directed program, entry at 0x02A
        begin_reset(9'h02A);
        for (int a = 0; a < 512; a++) load(9'(a), rand_word() & ~36'hF | 36'h1);
        load(9'h02A, mk(9'h040, 0, 0, 1, 4'h2));   // test Z
        load(9'h140, mk(9'h055, 0, 1, 0, 4'h3));   // test N
        load(9'h055, mk(9'h100, 1, 0, 0, 4'h1));   // dispatch into upper half
        load(9'h115, mk(9'h000, 1, 0, 0, 4'h0));   // plain byte jump
        load(9'h036, mk(9'h077, 0, 0, 0, 4'h5));   // no jump bits
        load(9'h077, mk(9'h078, 0, 0, 0, 4'hF));   // illegal source: halt
        end_reset();
        step(0, 1, 8'h00, 'h02A, "R2 R1 entry after reset");      // Z=1 latched
        step(0, 0, 8'h00, 'h140, "R3 Z taken +0x100");            // N=0 latched
        step(1, 1, 8'h00, 'h055, "R3 N false target");
        step(0, 0, 8'h15, 'h115, "R4 byte merge 0x100|0x15");
        step(1, 1, 8'h36, 'h036, "R5 byte jump with field zero"); // flags set, untested
        step(0, 0, 8'hFF, 'h077, "R9 R8 untested flags ignored");
        for (int i = 0; i < 4; i++)
            step(1'($urandom()), 1'($urandom()), 8'($urandom()), 'h077, "R6 halt freezes address");
        // R7: write the halt word while halted
        load(9'h077, mk(9'h010, 0, 0, 0, 4'h4));
        #1;
        chk(uinstr_o == mdl[9'h077], "R7 store writable while halted", uinstr_o, mdl[9'h077]);
        chk(halt_o == 1'b1, "R7 halt stays after rewrite", 36'(halt_o), 36'h1);
        @(negedge clk_i);
        begin_reset(9'h02A);
        end_reset();
        step(0, 0, 8'h00, 'h02A, "R7 restart at entry");
        step(0, 0, 8'h00, 'h040, "R3 Z false target");

        // Random programs
        for (int r = 0; r < 5; r++) begin
            int stall;
            stall = 0;
            begin_reset(9'($urandom()));
            for (int a = 0; a < 512; a++) load(9'(a), rand_word());
            end_reset();
            for (int s = 0; s < 500 && stall < 4; s++) begin
                if (m_halt) stall++;
                step(1'($urandom()), 1'($urandom()), 8'($urandom()), -1, "R8 random sequence");
            end
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule